// File: doc/BRIEF.md
# SMI Event Status and Enable Aggregator

This block gathers the system-management interrupt sources of a platform into sticky status bits, pairs each one with an enable bit, and drives a single active-low SMI line. The sources are a software SMI timer expiry strobe, a strobe for writes to the APM control port, a strobe for writes of 1 to the sleep-enable bit, a global-release write made through the block's own register bus, a vector of legacy USB status/enable pairs, and sixteen general-purpose inputs. Each general-purpose input has a two-bit routing field.

Software uses a small synchronous register bus to program enables, read status and clear status bits by writing 1. The bus has a write strobe, a byte address, 16-bit data and two byte enables. Reads are combinational from the address. The timer, the USB controller and power sequencing are not part of this block. They appear only as input strobes and levels.

Register map (16-bit registers, byte offsets). 04h is the control register: bit 2 is a global-release strobe and reads 0. 30h holds the source enables: bit 6 timer, bit 5 APM, bit 4 sleep, bit 3 USB, bit 2 BIOS. 34h is the source status register, with bits at the same positions as the enables. 38h is the 16-bit general-input SMI enable. 3Ch is the 16-bit general-input sticky status. 40h holds routing for inputs 0 to 7 and 42h holds routing for inputs 8 to 15. Input n uses bits 2(n mod 8)+1 : 2(n mod 8), and the code 01 selects SMI. Unused bits and unmapped addresses read 0.

Top module: `smi_aggregator`

## Requirements
- R1: After reset every register reads 0 and `smi_n_o` is 1.
- R2: A timer strobe sets status bit 6. Writing 1 to that bit at 34h clears it. Writing 0 leaves it unchanged.
- R3: An APM write strobe sets status bit 5 only when enable bit 5 at 30h is 1.
- R4: A sleep write-1 strobe sets status bit 4 only when enable bit 4 at 30h is 1.
- R5: Status bit 3 is read-only. It equals the OR over all USB sources of the source status ANDed with its own enable, so it is 0 whenever no USB enable is set.
- R6: Writing 1 to bit 2 at 04h sets status bit 2. An SMI results when status bit 2 and enable bit 2 are both 1.
- R7: The register at 38h is 16 bits wide, read/write, and resets to 0000h. Bit n belongs to general input n.
- R8: Each general input passes through a two-flop synchroniser. A rising edge sets its sticky bit at 3Ch, which is write-1-to-clear. The input causes an SMI only when its bit at 38h is 1, its routing code is 01 and the input is implemented. Unimplemented inputs never set status.
- R9: Bits 7, 1 and 0 of the status register at 34h always read 0.
- R10: If a set event and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R11: `smi_n_o` is registered. It goes low one clock after any status bit is pending together with its enable, and it stays high while all enables are 0.
- R12: Byte enable 0 gates bits 7:0 of a write and byte enable 1 gates bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables |
| rdata_o | output | 16 | Read data for `addr_i` |
| tmr_evt_i | input | 1 | Software SMI timer expiry strobe |
| apm_wr_i | input | 1 | APM control port write strobe |
| slp_wr1_i | input | 1 | Strobe for a write of 1 to the sleep-enable bit |
| usb_sts_i | input | USB_N | Legacy USB source status |
| usb_en_i | input | USB_N | Legacy USB source enables |
| gpi_i | input | 16 | Asynchronous general-purpose inputs |
| smi_n_o | output | 1 | Active-low SMI |

## Verification
The aggregation path is driven from a vector table. Each entry pairs an enable word with a combination of event strobes. This separates three cases: status latched without an SMI, status refused because its set condition is gated off, and a true SMI. Multi-event rows confirm that each source is qualified only by its own enable. The general inputs are raised in patterns that fail exactly one of the three qualifying conditions each, followed by one input that meets all three, so a missing term in the three-way AND shows up. Directed cases cover a set event that collides with a clear, a write of 0, partial byte enables, and USB masks that overlap or do not overlap.

// File: rtl/smi_aggregator.sv
module smi_aggregator #(
  parameter int          USB_N    = 4,
  parameter logic [15:0] GPI_IMPL = 16'hFF3F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [7:0]       addr_i,
  input  logic [15:0]      wdata_i,
  input  logic [1:0]       be_i,
  output logic [15:0]      rdata_o,
  input  logic             tmr_evt_i,
  input  logic             apm_wr_i,
  input  logic             slp_wr1_i,
  input  logic [USB_N-1:0] usb_sts_i,
  input  logic [USB_N-1:0] usb_en_i,
  input  logic [15:0]      gpi_i,
  output logic             smi_n_o
);
  localparam int         NGPI   = 16;
  localparam int         RWORDS = NGPI / 8;
  localparam logic [7:0] A_CTRL = 8'h04;
  localparam logic [7:0] A_EN   = 8'h30;
  localparam logic [7:0] A_STS  = 8'h34;
  localparam logic [7:0] A_ALT  = 8'h38;
  localparam logic [7:0] A_GSTS = 8'h3C;
  localparam logic [7:0] A_RT   = 8'h40;

  logic [15:0]       bemask, wmask;
  logic [6:2]        en_q;
  logic              tmr_sts, apm_sts, slp_sts, bios_sts, usb_sts;
  logic [NGPI-1:0]   alt_en, gpi_sts, s1, s2, s3, routed;
  logic [2*NGPI-1:0] route;
  logic              glr, pend, smi_n_q;

  assign bemask  = {{8{be_i[1]}}, {8{be_i[0]}}};
  assign wmask   = wr_i ? (wdata_i & bemask) : 16'h0;
  assign usb_sts = |(usb_sts_i & usb_en_i);
  assign glr     = (addr_i == A_CTRL) && wmask[2];

  always_comb
    for (int n = 0; n < NGPI; n++) routed[n] = (route[2*n +: 2] == 2'b01);

  assign pend = (tmr_sts & en_q[6]) | (apm_sts & en_q[5]) | (slp_sts & en_q[4]) |
                (usb_sts & en_q[3]) | (bios_sts & en_q[2]) |
                (|(gpi_sts & alt_en & routed & GPI_IMPL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      tmr_sts  <= 1'b0;
      apm_sts  <= 1'b0;
      slp_sts  <= 1'b0;
      bios_sts <= 1'b0;
      alt_en   <= '0;
      gpi_sts  <= '0;
      s1       <= '0;
      s2       <= '0;
      s3       <= '0;
      route    <= '0;
      smi_n_q  <= 1'b1;
    end else begin
      if (wr_i && addr_i == A_EN && be_i[0]) en_q <= wdata_i[6:2];
      if (wr_i && addr_i == A_ALT) alt_en <= (alt_en & ~bemask) | (wdata_i & bemask);
      for (int k = 0; k < RWORDS; k++)
        if (wr_i && addr_i == A_RT + 8'(2*k))
          route[16*k +: 16] <= (route[16*k +: 16] & ~bemask) | (wdata_i & bemask);
      if (addr_i == A_STS) begin
        tmr_sts  <= (tmr_sts  & ~wmask[6]) | tmr_evt_i;
        apm_sts  <= (apm_sts  & ~wmask[5]) | (apm_wr_i & en_q[5]);
        slp_sts  <= (slp_sts  & ~wmask[4]) | (slp_wr1_i & en_q[4]);
        bios_sts <= (bios_sts & ~wmask[2]) | glr;
      end else begin
        tmr_sts  <= tmr_sts  | tmr_evt_i;
        apm_sts  <= apm_sts  | (apm_wr_i & en_q[5]);
        slp_sts  <= slp_sts  | (slp_wr1_i & en_q[4]);
        bios_sts <= bios_sts | glr;
      end
      s1 <= gpi_i;
      s2 <= s1;
      s3 <= s2;
      gpi_sts <= ((addr_i == A_GSTS) ? (gpi_sts & ~wmask) : gpi_sts) | (s2 & ~s3 & GPI_IMPL);
      smi_n_q <= ~pend;
    end
  end

  assign smi_n_o = smi_n_q;

  always_comb begin
    rdata_o = 16'h0;
    unique case (addr_i)
      A_EN:    rdata_o = {9'h0, en_q, 2'b00};
      A_STS:   rdata_o = {9'h0, tmr_sts, apm_sts, slp_sts, usb_sts, bios_sts, 2'b00};
      A_ALT:   rdata_o = alt_en;
      A_GSTS:  rdata_o = gpi_sts;
      default: rdata_o = 16'h0;
    endcase
    for (int k = 0; k < RWORDS; k++)
      if (addr_i == A_RT + 8'(2*k)) rdata_o = route[16*k +: 16];
  end
endmodule

// File: rtl/smi_aggregator_chk.sv
module smi_aggregator_chk #(
  parameter int          USB_N    = 4,
  parameter logic [15:0] GPI_IMPL = 16'hFF3F
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_i,
  input logic [7:0]       addr_i,
  input logic [15:0]      wdata_i,
  input logic [1:0]       be_i,
  input logic [15:0]      rdata_o,
  input logic             tmr_evt_i,
  input logic             apm_wr_i,
  input logic [USB_N-1:0] usb_sts_i,
  input logic [USB_N-1:0] usb_en_i,
  input logic             smi_n_o,
  input logic [6:2]       en_q,
  input logic [15:0]      alt_en,
  input logic [15:0]      gpi_sts,
  input logic             tmr_sts,
  input logic             apm_sts
);
  localparam logic [7:0] A_STS = 8'h34;

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_evt_i |=> tmr_sts);

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == A_STS && be_i[0] && wdata_i[6] && !tmr_evt_i) |=> !tmr_sts);

  assert_apm_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!apm_sts && !(apm_wr_i && en_q[5])) |=> !apm_sts);

  assert_usb_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == A_STS && !(|(usb_sts_i & usb_en_i))) |-> !rdata_o[3]);

  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == A_STS) |-> (rdata_o[7] == 1'b0 && rdata_o[1:0] == 2'b00));

  assert_unimpl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gpi_sts & ~GPI_IMPL) == 16'h0);

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 5'h0 && alt_en == 16'h0) |=> smi_n_o);
endmodule

bind smi_aggregator smi_aggregator_chk #(.USB_N(USB_N), .GPI_IMPL(GPI_IMPL)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .be_i(be_i), .rdata_o(rdata_o), .tmr_evt_i(tmr_evt_i), .apm_wr_i(apm_wr_i),
  .usb_sts_i(usb_sts_i), .usb_en_i(usb_en_i), .smi_n_o(smi_n_o), .en_q(en_q),
  .alt_en(alt_en), .gpi_sts(gpi_sts), .tmr_sts(tmr_sts), .apm_sts(apm_sts));

// File: tb/sim_smi_aggregator.sv
`timescale 1ns/1ps
module sim_smi_aggregator;
  logic clk = 0, rst_n = 0, wr = 0;
  logic [7:0] addr = 0;
  logic [15:0] wdata = 0, rdata, gpi = 0;
  logic [1:0] be = 0;
  logic tmr = 0, apm = 0, slp = 0, smi_n;
  logic [3:0] usb_s = 0, usb_e = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  smi_aggregator u0 (.clk(clk), .rst_n(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .be_i(be), .rdata_o(rdata), .tmr_evt_i(tmr), .apm_wr_i(apm), .slp_wr1_i(slp),
    .usb_sts_i(usb_s), .usb_en_i(usb_e), .gpi_i(gpi), .smi_n_o(smi_n));

  // {enable word, events {tmr,apm,slp,global release}, expected status, expected smi_n}
  localparam logic [28:0] VEC [10] = '{
    {16'h0000, 4'b1000, 8'h40, 1'b1}, {16'h0040, 4'b1000, 8'h40, 1'b0},
    {16'h0000, 4'b0100, 8'h00, 1'b1}, {16'h0020, 4'b0100, 8'h20, 1'b0},
    {16'h0000, 4'b0010, 8'h00, 1'b1}, {16'h0010, 4'b0010, 8'h10, 1'b0},
    {16'h0000, 4'b0001, 8'h04, 1'b1}, {16'h0004, 4'b0001, 8'h04, 1'b0},
    {16'h0074, 4'b1111, 8'h74, 1'b0}, {16'h0020, 4'b1010, 8'h40, 1'b1}};

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [7:0] a, logic [15:0] d, logic [1:0] b);
    @(negedge clk); wr = 1; addr = a; wdata = d; be = b;
    @(negedge clk); wr = 0; be = 0;
  endtask

  task automatic rreg(logic [7:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 0; gpi = 0; usb_s = 0; usb_e = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    do_reset();
    rreg(8'h30, d); check("R1 enable reset", d, 16'h0);
    rreg(8'h34, d); check("R1 status reset", d, 16'h0);
    rreg(8'h38, d); check("R1/R7 alt enable reset", d, 16'h0);
    rreg(8'h3C, d); check("R1 gpi status reset", d, 16'h0);
    rreg(8'h40, d); check("R1 route reset", d, 16'h0);
    check("R1 smi_n reset", {15'h0, smi_n}, 16'h1);

    foreach (VEC[i]) begin
      wreg(8'h30, VEC[i][28:13], 2'b11);
      wreg(8'h34, 16'h00FF, 2'b01);
      tmr = VEC[i][12]; apm = VEC[i][11]; slp = VEC[i][10];
      if (VEC[i][9]) begin wr = 1; addr = 8'h04; wdata = 16'h0004; be = 2'b01; end
      @(negedge clk);
      tmr = 0; apm = 0; slp = 0; wr = 0; be = 0;
      rreg(8'h34, d); check($sformatf("R2/R3/R4/R6 vector %0d status", i), d, {8'h0, VEC[i][8:1]});
      @(negedge clk);
      check($sformatf("R11 vector %0d smi_n", i), {15'h0, smi_n}, {15'h0, VEC[i][0]});
    end

    rreg(8'h34, d); check("R9 reserved bits", d & 16'h0083, 16'h0);

    do_reset();
    @(negedge clk); tmr = 1; wr = 1; addr = 8'h34; wdata = 16'h0040; be = 2'b01;
    @(negedge clk); tmr = 0; wr = 0; be = 0;
    rreg(8'h34, d); check("R10 set beats clear", d, 16'h0040);
    wreg(8'h34, 16'h0000, 2'b11);
    rreg(8'h34, d); check("R2 write 0 no effect", d, 16'h0040);
    wreg(8'h34, 16'h0040, 2'b01);
    rreg(8'h34, d); check("R2 write 1 clears", d, 16'h0000);

    usb_s = 4'b0101; usb_e = 4'b1010; @(negedge clk);
    rreg(8'h34, d); check("R5 disjoint masks", d, 16'h0000);
    wreg(8'h34, 16'h0008, 2'b01);
    usb_e = 4'b0001;
    rreg(8'h34, d); check("R5 overlap sets bit 3", d, 16'h0008);
    wreg(8'h34, 16'h0008, 2'b01);
    rreg(8'h34, d); check("R5 read-only bit", d, 16'h0008);
    wreg(8'h30, 16'h0008, 2'b01);
    @(negedge clk);
    check("R11 usb smi", {15'h0, smi_n}, 16'h0);
    usb_e = 0;

    wreg(8'h30, 16'h0000, 2'b10);
    rreg(8'h30, d); check("R12 upper-byte write leaves enables", d, 16'h0008);
    wreg(8'h38, 16'hA55A, 2'b11);
    rreg(8'h38, d); check("R7 alt enable rw", d, 16'hA55A);
    wreg(8'h38, 16'hFFFF, 2'b01);
    rreg(8'h38, d); check("R12 low byte only", d, 16'hA5FF);

    do_reset();
    wreg(8'h38, 16'h0043, 2'b11);
    wreg(8'h40, 16'h1019, 2'b11);
    rreg(8'h40, d); check("R8 route readback", d, 16'h1019);
    @(negedge clk); gpi = 16'h0046;
    repeat (5) @(negedge clk);
    rreg(8'h3C, d); check("R8 sticky, unimplemented stays 0", d, 16'h0006);
    check("R8 no qualified input", {15'h0, smi_n}, 16'h1);
    gpi = 16'h0047;
    repeat (5) @(negedge clk);
    rreg(8'h3C, d); check("R8 qualified status", d, 16'h0007);
    check("R8 qualified smi", {15'h0, smi_n}, 16'h0);
    wreg(8'h3C, 16'h0001, 2'b01);
    rreg(8'h3C, d); check("R8 clear without new edge", d, 16'h0006);
    @(negedge clk);
    check("R8 smi released", {15'h0, smi_n}, 16'h1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule